// File: doc/BRIEF.md
# Power Mode Controller

This block decides which clock domains of a small microcontroller are allowed to run. It works in four operating modes. Each mode has a fixed set of clock enables for five consumers: the fast main-clock domain, the slow-clock domain, the CPU, the general peripherals and the timer/watchdog unit. Software picks a mode by writing a control register. Once the CPU has been stopped, only a wake event can change the mode.

Wake events come from an eight-channel edge detector. Every channel has its own enable and its own choice of rising or falling edge. A detected edge sets a sticky pending flag, which software clears by writing a one to it. The same pending flags, filtered by a mask, drive one combined interrupt, so the channels also serve as general-purpose edge interrupts.

The slow-clock tick comes either from an external strobe or from a prescaler that divides the main clock by a programmable factor. After a halt, the fast clock is released only once a programmable number of slow ticks has been counted.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After a synchronous reset the mode status reads 0 (Active), all five clock enables are 1, all pending flags are 0 and the interrupt is 0.
- R2: The mode codes are 0 Active, 1 Power Save, 2 Idle and 3 Halt. The enables {fast, slow, cpu, periph, twm} are 11111 in Active, 01111 in Power Save, 01001 in Idle and 00000 in Halt.
- R3: The control register is at address 0. It holds the requested mode in bits [1:0] and the save-exit flag in bit 2. A write in Active or Power Save makes the mode status show the requested mode one clock later.
- R4: A channel's pending flag is set only when that channel is enabled (address 1, bit per channel) and its input makes the selected edge (address 2: bit 0 = rising, 1 = falling). The flag becomes visible 3 clocks after the input changes.
- R5: Pending flags are sticky. Writing address 3 clears each flag whose data bit is 1 and leaves the others alone.
- R6: The interrupt is the OR of the pending flags ANDed with the mask at address 5. It follows a mask write in the same cycle that the mask register changes.
- R7: In Idle, any pending flag moves the block to Active one clock later. In Idle and Halt, writes to the mode field are ignored.
- R8: In Halt, a pending flag starts a stabilisation phase. In this phase the status stays at 3, only the slow enable is 1, and the block waits for the number of slow ticks held at address 4. On the following clock it enters Active.
- R9: In Power Save, a pending flag moves the block to Active only if the save-exit flag is 1. Otherwise the block stays in Power Save.
- R10: With the external-source select at 0, the slow tick is a one-cycle pulse every (divider+1) main clocks. With the select at 1, the tick follows the external strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| presc_div | input | 16 | Slow-tick prescaler divider |
| slow_src_ext | input | 1 | 1 selects the external slow strobe |
| ext_slow_tick | input | 1 | External slow-clock strobe |
| wake_in | input | 8 | Asynchronous wake inputs |
| clk_en_fast | output | 1 | Fast domain clock enable |
| clk_en_slow | output | 1 | Slow domain clock enable |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_periph | output | 1 | Peripheral clock enable |
| clk_en_twm | output | 1 | Timer/watchdog clock enable |
| mode_stat | output | 2 | Current mode code |
| wake_pend | output | 8 | Pending wake flags |
| wake_irq | output | 1 | Combined masked wake interrupt |
| slow_tick | output | 1 | Slow-clock tick strobe |

## Verification
The hardest state to reach is the stabilisation phase after a halt. Getting there takes a Halt write, an edge-select setting that makes a fresh edge the only trigger, and a wake edge on an armed channel. Once there, the bench follows the outputs cycle by cycle. It counts the slow ticks seen while the status still reads Halt with only the slow enable high, and it checks that Active appears only after the programmed count. Power Save exits are tested with the save-exit flag both clear and set, and each case uses an edge that arrives after the mode has been entered.

// File: rtl/pmc_pkg.sv
// Shared types for the power mode controller.
// Assumes the mode code values are visible to software and must stay fixed.
package pmc_pkg;
    typedef enum logic [1:0] {
        MODE_ACT  = 2'd0,
        MODE_PS   = 2'd1,
        MODE_IDLE = 2'd2,
        MODE_HALT = 2'd3
    } pmode_e;

    typedef enum logic [2:0] {
        S_ACT, S_PS, S_IDLE, S_HALT, S_STAB
    } pstate_e;

    typedef struct packed {
        logic fast;
        logic slow;
        logic cpu;
        logic periph;
        logic twm;
    } clk_en_t;

    localparam logic [2:0] A_CTL  = 3'd0;
    localparam logic [2:0] A_WEN  = 3'd1;
    localparam logic [2:0] A_EDGE = 3'd2;
    localparam logic [2:0] A_CLR  = 3'd3;
    localparam logic [2:0] A_STAB = 3'd4;
    localparam logic [2:0] A_MASK = 3'd5;
endpackage

// File: rtl/pmc_regs.sv
// Register file for the controller: stores the configuration and turns
// control writes into one-cycle pulses. Assumes NCH <= DW and STW <= DW.
module pmc_regs
    import pmc_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 8,
    parameter int STW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_addr,
    input  logic [DW-1:0]  wr_data,
    output logic           mode_wr,
    output pmode_e         mode_req,
    output logic           ps_exit,
    output logic [NCH-1:0] wake_en,
    output logic [NCH-1:0] edge_fall,
    output logic [NCH-1:0] irq_mask,
    output logic [NCH-1:0] pend_clr,
    output logic [STW-1:0] stab_val
);
    // Write pulses that are decoded straight from the bus.
    always_comb begin
        mode_wr  = wr_en && (wr_addr == A_CTL);
        mode_req = pmode_e'(wr_data[1:0]);
        pend_clr = (wr_en && (wr_addr == A_CLR)) ? wr_data[NCH-1:0] : '0;
    end

    // Stored configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_exit   <= 1'b0;
            wake_en   <= '0;
            edge_fall <= '0;
            irq_mask  <= '0;
            stab_val  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTL:   ps_exit   <= wr_data[2];
                A_WEN:   wake_en   <= wr_data[NCH-1:0];
                A_EDGE:  edge_fall <= wr_data[NCH-1:0];
                A_MASK:  irq_mask  <= wr_data[NCH-1:0];
                A_STAB:  stab_val  <= wr_data[STW-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pmc_prescaler.sv
// Slow-tick source: divides the main clock by (div+1), or passes an external
// strobe through. Assumes the external strobe is synchronous to clk.
module pmc_prescaler #(
    parameter int PDW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [PDW-1:0] div,
    input  logic           sel_ext,
    input  logic           ext_tick,
    output logic           tick
);
    logic [PDW-1:0] cnt;
    logic           int_tick;

    // Divider counter that pulses int_tick once per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            int_tick <= 1'b0;
        end else if (cnt >= div) begin
            cnt      <= '0;
            int_tick <= 1'b1;
        end else begin
            cnt      <= cnt + 1'b1;
            int_tick <= 1'b0;
        end
    end

    // Source selection.
    assign tick = sel_ext ? ext_tick : int_tick;

    // R10: an internal tick lasts one cycle when the divider is above zero.
    a_r10_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (int_tick && div != '0 && $stable(div)) |=> !int_tick);
endmodule

// File: rtl/pmc_wake.sv
// Wake unit: one synchroniser and edge detector per channel, sticky pending
// flags cleared by writing ones, and a masked combined interrupt.
// Assumes wake inputs are asynchronous to clk.
module pmc_wake #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin,
    input  logic [NCH-1:0] en,
    input  logic [NCH-1:0] fall,
    input  logic [NCH-1:0] mask,
    input  logic [NCH-1:0] clr,
    output logic [NCH-1:0] pend,
    output logic           irq
);
    logic [NCH-1:0] hit;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic s1, s2, prev;
        // Two-flop synchroniser followed by the previous-value register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1   <= 1'b0;
                s2   <= 1'b0;
                prev <= 1'b0;
            end else begin
                s1   <= pin[i];
                s2   <= s1;
                prev <= s2;
            end
        end
        // Edge match for the selected polarity.
        assign hit[i] = en[i] && (fall[i] ? (prev && !s2) : (!prev && s2));
    end

    // Pending flags: a new edge wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | hit;
    end

    // Combined masked interrupt.
    assign irq = |(pend & mask);

    // R4: a flag can only appear on a channel that was enabled.
    a_r4_new_pend_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(en)) == '0));
    // R5: a flag only drops when its clear bit was written.
    a_r5_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend) & ~$past(clr) & ~pend) == '0));
endmodule

// File: rtl/pmc_fsm.sv
// Mode sequencer: tracks the current mode, reacts to software requests and
// wake events, counts the stabilisation ticks after a halt, and produces the
// clock enables. Assumes wake is level-true while any flag is pending.
module pmc_fsm
    import pmc_pkg::*;
#(
    parameter int STW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_wr,
    input  pmode_e         mode_req,
    input  logic           ps_exit,
    input  logic           wake,
    input  logic           slow_tick,
    input  logic [STW-1:0] stab_val,
    output clk_en_t        en,
    output pmode_e         mode_stat
);
    pstate_e        st, st_nx;
    logic [STW-1:0] cnt;

    function automatic pstate_e req2st(input pmode_e m);
        case (m)
            MODE_PS:   return S_PS;
            MODE_IDLE: return S_IDLE;
            MODE_HALT: return S_HALT;
            default:   return S_ACT;
        endcase
    endfunction

    // Next-state selection.
    always_comb begin
        st_nx = st;
        case (st)
            S_ACT:  if (mode_wr) st_nx = req2st(mode_req);
            S_PS: begin
                if (wake && ps_exit) st_nx = S_ACT;
                else if (mode_wr)    st_nx = req2st(mode_req);
            end
            S_IDLE: if (wake) st_nx = S_ACT;
            S_HALT: if (wake) st_nx = S_STAB;
            S_STAB: if (cnt >= stab_val) st_nx = S_ACT;
            default: st_nx = S_ACT;
        endcase
    end

    // State register and stabilisation counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= S_ACT;
            cnt <= '0;
        end else begin
            st <= st_nx;
            if (st != S_STAB)  cnt <= '0;
            else if (slow_tick && cnt < stab_val) cnt <= cnt + 1'b1;
        end
    end

    // Clock enables and reported mode for each state.
    always_comb begin
        case (st)
            S_ACT:   begin en = 5'b11111; mode_stat = MODE_ACT;  end
            S_PS:    begin en = 5'b01111; mode_stat = MODE_PS;   end
            S_IDLE:  begin en = 5'b01001; mode_stat = MODE_IDLE; end
            S_HALT:  begin en = 5'b00000; mode_stat = MODE_HALT; end
            S_STAB:  begin en = 5'b01000; mode_stat = MODE_HALT; end
            default: begin en = 5'b11111; mode_stat = MODE_ACT;  end
        endcase
    end

    // R7: Idle holds while nothing is pending.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !wake) |=> st == S_IDLE);
    // R7: Halt leaves only through stabilisation.
    a_r7_halt_path: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HALT) |=> (st == S_HALT || st == S_STAB));
    // R8: stabilisation holds until the count is reached.
    a_r8_stab_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_STAB && cnt < stab_val) |=> st == S_STAB);
    // R9: Power Save holds without a request or a permitted wake.
    a_r9_ps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PS && !mode_wr && !(wake && ps_exit)) |=> st == S_PS);
endmodule

// File: rtl/pwr_mode_ctl.sv
// Top level of the power mode controller: connects the registers, the
// slow-tick prescaler, the wake unit and the mode sequencer.
// Assumes one clock domain; wake_in is the only asynchronous input.
module pwr_mode_ctl
    import pmc_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 8,
    parameter int PDW = 16,
    parameter int STW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [PDW-1:0] presc_div,
    input  logic           slow_src_ext,
    input  logic           ext_slow_tick,
    input  logic [NCH-1:0] wake_in,
    output logic           clk_en_fast,
    output logic           clk_en_slow,
    output logic           clk_en_cpu,
    output logic           clk_en_periph,
    output logic           clk_en_twm,
    output logic [1:0]     mode_stat,
    output logic [NCH-1:0] wake_pend,
    output logic           wake_irq,
    output logic           slow_tick
);
    logic           mode_wr, ps_exit;
    pmode_e         mode_req, stat;
    logic [NCH-1:0] wake_en, edge_fall, irq_mask, pend_clr;
    logic [STW-1:0] stab_val;
    clk_en_t        en;

    pmc_regs #(.NCH(NCH), .DW(DW), .STW(STW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode_wr(mode_wr), .mode_req(mode_req),
        .ps_exit(ps_exit), .wake_en(wake_en), .edge_fall(edge_fall),
        .irq_mask(irq_mask), .pend_clr(pend_clr), .stab_val(stab_val)
    );

    pmc_prescaler #(.PDW(PDW)) u_presc (
        .clk(clk), .rst_n(rst_n), .div(presc_div), .sel_ext(slow_src_ext),
        .ext_tick(ext_slow_tick), .tick(slow_tick)
    );

    pmc_wake #(.NCH(NCH)) u_wake (
        .clk(clk), .rst_n(rst_n), .pin(wake_in), .en(wake_en),
        .fall(edge_fall), .mask(irq_mask), .clr(pend_clr),
        .pend(wake_pend), .irq(wake_irq)
    );

    pmc_fsm #(.STW(STW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_req(mode_req),
        .ps_exit(ps_exit), .wake(|wake_pend), .slow_tick(slow_tick),
        .stab_val(stab_val), .en(en), .mode_stat(stat)
    );

    // Flatten the enable bundle onto the ports.
    always_comb begin
        clk_en_fast   = en.fast;
        clk_en_slow   = en.slow;
        clk_en_cpu    = en.cpu;
        clk_en_periph = en.periph;
        clk_en_twm    = en.twm;
        mode_stat     = stat;
    end

    // R2: the CPU never runs while its slow clock is gated.
    a_r2_cpu_needs_slow: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_cpu |-> clk_en_slow);
endmodule

// File: tb/sim_pwr_mode_ctl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] presc_div = 16'd3;
    logic        slow_src_ext = 1'b0;
    logic        ext_slow_tick = 1'b0;
    logic [7:0]  wake_in = '0;
    logic        clk_en_fast, clk_en_slow, clk_en_cpu, clk_en_periph, clk_en_twm;
    logic [1:0]  mode_stat;
    logic [7:0]  wake_pend;
    logic        wake_irq, slow_tick;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct { string tag; logic [6:0] v; } sb_item_t;
    sb_item_t sbq[$];
    event     sb_ev;

    always #2.5 clk = ~clk;

    pwr_mode_ctl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .presc_div(presc_div), .slow_src_ext(slow_src_ext),
        .ext_slow_tick(ext_slow_tick), .wake_in(wake_in),
        .clk_en_fast(clk_en_fast), .clk_en_slow(clk_en_slow),
        .clk_en_cpu(clk_en_cpu), .clk_en_periph(clk_en_periph),
        .clk_en_twm(clk_en_twm), .mode_stat(mode_stat), .wake_pend(wake_pend),
        .wake_irq(wake_irq), .slow_tick(slow_tick)
    );

    function automatic logic [6:0] outs();
        return {clk_en_fast, clk_en_slow, clk_en_cpu, clk_en_periph, clk_en_twm, mode_stat};
    endfunction

    // Expected enables and status per mode code, from R2.
    function automatic logic [6:0] mode_vec(input logic [1:0] m);
        case (m)
            2'd0:    return {5'b11111, 2'd0};
            2'd1:    return {5'b01111, 2'd1};
            2'd2:    return {5'b01001, 2'd2};
            default: return {5'b00000, 2'd3};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver side of the scoreboard: push an expected output item.
    task automatic expect_mode(input string tag, input logic [1:0] m);
        sb_item_t it;
        it.tag = tag;
        it.v   = mode_vec(m);
        sbq.push_back(it);
        -> sb_ev;
    endtask

    // Monitor: pops expected items and compares them with the outputs.
    initial forever begin
        @(sb_ev);
        while (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            chk(it.tag, 32'(outs()), 32'(it.v));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n, ticks;
        bit saw_stab, fast_leak;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        expect_mode("R1 reset enables", 2'd0);
        chk("R1 reset pending", 32'(wake_pend), 0);
        chk("R1 reset irq", 32'(wake_irq), 0);

        // R10: internal divider period and external pass-through.
        n = 0;
        while (!slow_tick && n < 20) begin @(negedge clk); n++; end
        n = 0;
        do begin @(negedge clk); n++; end while (!slow_tick && n < 20);
        chk("R10 tick period", 32'(n), 4);
        slow_src_ext = 1'b1;
        @(negedge clk);
        chk("R10 ext low", 32'(slow_tick), 0);
        ext_slow_tick = 1'b1;
        #1 chk("R10 ext high", 32'(slow_tick), 1);
        @(negedge clk);
        ext_slow_tick = 1'b0;
        slow_src_ext  = 1'b0;

        // R3/R2: enter Power Save, save-exit flag clear.
        wr(3'd0, 8'h01);
        expect_mode("R3 R2 power save", 2'd1);
        wr(3'd1, 8'h21);
        wr(3'd2, 8'h00);
        // R9: a wake edge in Power Save without the flag keeps the mode.
        wake_in[0] = 1'b1;
        cyc(6);
        chk("R4 rising pend", 32'(wake_pend), 32'h01);
        expect_mode("R9 stays in save", 2'd1);
        wr(3'd3, 8'h01);
        chk("R5 w1c clears", 32'(wake_pend), 0);
        wr(3'd0, 8'h05);
        expect_mode("R9 flag set, still save", 2'd1);
        // R4: a falling edge on a rising-configured channel is ignored.
        wake_in[0] = 1'b0;
        cyc(6);
        chk("R4 wrong edge ignored", 32'(wake_pend), 0);
        expect_mode("R4 no wake from wrong edge", 2'd1);
        // R4/R9: latency of a rising edge and exit with the flag set.
        wake_in[0] = 1'b1;
        cyc(3);
        chk("R4 pend after 3 clocks", 32'(wake_pend), 32'h01);
        expect_mode("R9 not yet active", 2'd1);
        cyc(1);
        expect_mode("R9 save exits to active", 2'd0);
        wr(3'd3, 8'hFF);

        // R7: Idle, ignored mode write, disabled channel, falling wake.
        wake_in[5] = 1'b1;
        wr(3'd2, 8'h20);
        wr(3'd0, 8'h02);
        expect_mode("R2 idle enables", 2'd2);
        wr(3'd0, 8'h00);
        expect_mode("R7 idle ignores write", 2'd2);
        wake_in[3] = 1'b1;
        cyc(6);
        chk("R4 disabled channel", 32'(wake_pend), 0);
        expect_mode("R7 idle held", 2'd2);
        wake_in[5] = 1'b0;
        cyc(6);
        expect_mode("R7 idle wakes to active", 2'd0);
        chk("R4 falling pend", 32'(wake_pend), 32'h20);

        // R6: masked interrupt; R5: zero bits leave flags alone.
        chk("R6 masked off", 32'(wake_irq), 0);
        wr(3'd5, 8'h20);
        chk("R6 unmasked", 32'(wake_irq), 1);
        wr(3'd3, 8'h01);
        chk("R5 other bit kept", 32'(wake_pend), 32'h20);
        wr(3'd3, 8'h20);
        chk("R5 cleared", 32'(wake_pend), 0);
        chk("R6 irq drops", 32'(wake_irq), 0);

        // R8: Halt and stabilisation.
        wake_in[0] = 1'b0;
        cyc(5);
        wr(3'd3, 8'hFF);
        wr(3'd4, 8'd3);
        wr(3'd0, 8'h03);
        expect_mode("R2 halt enables", 2'd3);
        wr(3'd0, 8'h00);
        expect_mode("R7 halt ignores write", 2'd3);
        wake_in[0] = 1'b1;
        ticks = 0; saw_stab = 0; fast_leak = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (mode_stat == 2'd3 && clk_en_slow) begin
                if (!saw_stab) chk("R8 stab enables", 32'(outs()), 32'({5'b01000, 2'd3}));
                saw_stab = 1;
                if (clk_en_fast) fast_leak = 1;
                if (slow_tick) ticks++;
            end
            if (mode_stat == 2'd0) break;
        end
        chk("R8 stab phase seen", 32'(saw_stab), 1);
        chk("R8 fast held off", 32'(fast_leak), 0);
        chk("R8 ticks counted", 32'(ticks), 3);
        expect_mode("R8 active after stab", 2'd0);

        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule